// File: doc/BRIEF.md
# Embedded Timing Code Inserter for 4:2:2 Video

This block turns a multiplexed 4:2:2 sample stream that travels alongside separate flags (active video, field identity, vertical blanking) into one self-timed word stream. The stream carries its own timing reference codes, so no separate sync wires are needed. A start code goes out in the four words just before the first sample of each active region. An end code goes out in the four words just after the last sample. Between codes, the output carries blanking levels.

Each code is a run of four words: all ones, zero, zero, and then a status word. The status word holds the field bit, the vertical bit and the start/end bit. It also holds four protection bits derived from those three. The data path runs through a fixed four-word delay, which leaves room for the start code ahead of the samples it announces. Active samples are limited so they never take a value reserved for the codes.

Top module: `vtrs_inserter`

## Requirements
- R1: While `rst` is high and in the first clock after it is released (with inactive input), `vid_out` holds blanking: 0x040 during reset and 0x200 as the first word afterwards.
- R2: When `act_in` is sampled high after a low sample (or as the first sample after reset) at clock edge n, the words registered at edges n, n+1, n+2 and n+3 are 0x3FF, 0x000, 0x000 and a status word with H=0. F and V in that status word are the `fld_in`/`vbl_in` of the sample at edge n.
- R3: Each input sample is presented on `vid_out` exactly four clocks after it is sampled, so the first active word directly follows the start code.
- R4: When the sample at edge n is the first inactive one after an active region, the four words registered at edges n+4..n+7 are 0x3FF, 0x000, 0x000 and a status word with H=1. F and V in that status word come from the sample at edge n.
- R5: The status word, from bit 9 down to bit 0, is 1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0.
- R6: Active samples with V=0 are limited to the range 0x004..0x3FB. Values below that range become 0x004, values above it become 0x3FB, and values inside it pass unchanged.
- R7: Words that are neither code words nor active data alternate between 0x200 and 0x040. The first such word after each code is 0x200.
- R8: An active sample carrying V=1 is output as a blanking word in the alternating 0x200/0x040 sequence, and its data is not shown.
- R9: When every active region lasts at least one sample and is separated from the next by at least eight inactive samples, every code is sent complete, and no code begins while another is in progress.
- R10: The values 0x3FF and 0x000 appear on `vid_out` only as code words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, one word per cycle |
| rst | input | 1 | Synchronous reset, active high |
| vid_in | input | W | Multiplexed 4:2:2 sample, Cb first in each active region |
| act_in | input | 1 | Sample belongs to the active region |
| fld_in | input | 1 | Field identity for the sample |
| vbl_in | input | 1 | Vertical blanking for the sample |
| vid_out | output | W | Output stream with embedded timing codes |

## Verification
The bench builds the block with its default 10-bit width, where the status-word layout and the reserved code values are fully defined. It sends one long active region whose samples take every value from 0 to 1023, so the limiting is checked exhaustively at both ends. It also sends many short lines that cover every pairing of field and vertical flags for both start and end codes, active lengths down to a single sample, and blanking gaps down to the eight-sample minimum. Every output word is compared with a stream computed arithmetically from the input list.

// File: rtl/vtrs_pkg.sv
package vtrs_pkg;

  // Number of words in one timing reference code.
  localparam int CODE_LEN = 4;

  typedef struct packed {
    logic act;
    logic fld;
    logic vbl;
  } vtrs_tag_t;

  // Upper eight bits of the status word: marker, flags, protection bits.
  function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vtrs_delay_line.sv
module vtrs_delay_line
  import vtrs_pkg::*;
#(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  in_data,
  input  vtrs_tag_t     in_tag,
  output vtrs_tag_t     head_tag,
  output logic [W-1:0]  tap_data,
  output vtrs_tag_t     tap_tag
);

  logic [DEPTH-1:0][W-1:0] data_q;
  vtrs_tag_t [DEPTH-1:0]   tag_q;

  // Data stages carry no reset so they can map onto shift-register cells.
  always_ff @(posedge clk) begin
    data_q[0] <= in_data;
    for (int i = 1; i < DEPTH; i++) begin
      data_q[i] <= data_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else begin
      tag_q[0] <= in_tag;
      for (int i = 1; i < DEPTH; i++) begin
        tag_q[i] <= tag_q[i-1];
      end
    end
  end

  assign head_tag = tag_q[0];
  assign tap_data = data_q[DEPTH-1];
  assign tap_tag  = tag_q[DEPTH-1];

endmodule

// File: rtl/vtrs_code_seq.sv
module vtrs_code_seq
  import vtrs_pkg::*;
#(
  parameter int LEN = CODE_LEN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sav_start,
  input  logic                    sav_f,
  input  logic                    sav_v,
  input  logic                    eav_start,
  input  logic                    eav_f,
  input  logic                    eav_v,
  output logic                    code_on,
  output logic [$clog2(LEN)-1:0]  code_idx,
  output logic                    code_last,
  output logic                    code_h,
  output logic                    code_f,
  output logic                    code_v
);

  localparam int IW = $clog2(LEN);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic          h_q, f_q, v_q;
  logic          start;
  logic          new_h, new_f, new_v;

  assign start = sav_start | eav_start;
  // An end code wins if both ever coincide (outside the stated spacing).
  assign new_h = eav_start;
  assign new_f = eav_start ? eav_f : sav_f;
  assign new_v = eav_start ? eav_v : sav_v;

  assign code_on   = start | busy_q;
  assign code_idx  = start ? '0 : idx_q;
  assign code_last = code_on && (code_idx == LAST);
  assign code_h    = start ? new_h : h_q;
  assign code_f    = start ? new_f : f_q;
  assign code_v    = start ? new_v : v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      h_q    <= 1'b0;
      f_q    <= 1'b0;
      v_q    <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= IW'(1);
      h_q    <= new_h;
      f_q    <= new_f;
      v_q    <= new_v;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  // R2: a code releases the sequencer right after its last word.
  assert_code_len_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q == LAST && !start) |=> !busy_q);

  // R9: with legal spacing no new code starts inside a running one.
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q != LAST) |-> !start);

endmodule

// File: rtl/vtrs_word_fmt.sv
module vtrs_word_fmt
  import vtrs_pkg::*;
#(
  parameter int W   = 10,
  parameter int LEN = CODE_LEN
) (
  input  logic                    code_on,
  input  logic [$clog2(LEN)-1:0]  code_idx,
  input  logic                    code_h,
  input  logic                    code_f,
  input  logic                    code_v,
  input  logic [W-1:0]            tap_data,
  input  vtrs_tag_t               tap_tag,
  input  logic                    phase,
  output logic [W-1:0]            word
);

  localparam int IW  = $clog2(LEN);
  localparam int LSB = W - 8;
  localparam logic [W-1:0] RSV    = W'(1) << LSB;
  localparam logic [W-1:0] LO     = RSV;
  localparam logic [W-1:0] HI     = {W{1'b1}} - RSV;
  localparam logic [W-1:0] CHROMA = W'(1) << (W - 1);
  localparam logic [W-1:0] LUMA   = W'(16) << LSB;
  localparam logic [IW-1:0] LAST  = IW'(LEN - 1);

  logic [W-1:0] status;
  logic [W-1:0] limited;

  generate
    if (LSB > 0) begin : g_pad
      assign status = {status_byte(code_f, code_v, code_h), {LSB{1'b0}}};
    end else begin : g_nopad
      assign status = status_byte(code_f, code_v, code_h);
    end
  endgenerate

  always_comb begin
    if (tap_data < LO)      limited = LO;
    else if (tap_data > HI) limited = HI;
    else                    limited = tap_data;
  end

  always_comb begin
    if (code_on) begin
      if (code_idx == '0)        word = '1;
      else if (code_idx == LAST) word = status;
      else                       word = '0;
    end else if (tap_tag.act && !tap_tag.vbl) begin
      word = limited;
    end else begin
      word = phase ? LUMA : CHROMA;
    end
  end

endmodule

// File: rtl/vtrs_inserter.sv
module vtrs_inserter
  import vtrs_pkg::*;
#(
  parameter int W = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  vid_in,
  input  logic          act_in,
  input  logic          fld_in,
  input  logic          vbl_in,
  output logic [W-1:0]  vid_out
);

  localparam int IW  = $clog2(CODE_LEN);
  localparam int LSB = W - 8;
  localparam logic [W-1:0] RSV    = W'(1) << LSB;
  localparam logic [W-1:0] LO     = RSV;
  localparam logic [W-1:0] HI     = {W{1'b1}} - RSV;
  localparam logic [W-1:0] CHROMA = W'(1) << (W - 1);
  localparam logic [W-1:0] LUMA   = W'(16) << LSB;
  localparam logic [IW-1:0] LAST  = IW'(CODE_LEN - 1);

  vtrs_tag_t     in_tag, head_tag, tap_tag;
  logic [W-1:0]  tap_data;
  logic          tap_act_q;
  logic          sav_start, eav_start;
  logic          code_on, code_last, code_h, code_f, code_v;
  logic [IW-1:0] code_idx;
  logic          phase_q;
  logic [W-1:0]  next_word;
  logic          out_code_q;
  logic [IW-1:0] out_idx_q;

  assign in_tag = '{act: act_in, fld: fld_in, vbl: vbl_in};

  vtrs_delay_line #(.W(W), .DEPTH(CODE_LEN)) i_delay (
    .clk      (clk),
    .rst      (rst),
    .in_data  (vid_in),
    .in_tag   (in_tag),
    .head_tag (head_tag),
    .tap_data (tap_data),
    .tap_tag  (tap_tag)
  );

  // Start code fires on the undelayed rising edge; end code on the delayed falling edge.
  assign sav_start = act_in && !head_tag.act;
  assign eav_start = !tap_tag.act && tap_act_q;

  vtrs_code_seq #(.LEN(CODE_LEN)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .sav_start (sav_start),
    .sav_f     (fld_in),
    .sav_v     (vbl_in),
    .eav_start (eav_start),
    .eav_f     (tap_tag.fld),
    .eav_v     (tap_tag.vbl),
    .code_on   (code_on),
    .code_idx  (code_idx),
    .code_last (code_last),
    .code_h    (code_h),
    .code_f    (code_f),
    .code_v    (code_v)
  );

  vtrs_word_fmt #(.W(W), .LEN(CODE_LEN)) i_fmt (
    .code_on  (code_on),
    .code_idx (code_idx),
    .code_h   (code_h),
    .code_f   (code_f),
    .code_v   (code_v),
    .tap_data (tap_data),
    .tap_tag  (tap_tag),
    .phase    (phase_q),
    .word     (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_out    <= LUMA;
      phase_q    <= 1'b0;
      tap_act_q  <= 1'b0;
      out_code_q <= 1'b0;
      out_idx_q  <= '0;
    end else begin
      vid_out    <= next_word;
      tap_act_q  <= tap_tag.act;
      out_code_q <= code_on;
      out_idx_q  <= code_idx;
      if (code_on) begin
        if (code_last) phase_q <= 1'b0;
      end else begin
        phase_q <= !phase_q;
      end
    end
  end

  // R10: reserved extremes only appear as code words.
  assert_reserved_only_code_R10: assert property (@(posedge clk) disable iff (rst)
    (vid_out == {W{1'b1}} || vid_out == {W{1'b0}}) |-> out_code_q);

  // R5: the status word carries consistent protection bits.
  assert_status_parity_R5: assert property (@(posedge clk) disable iff (rst)
    (out_code_q && out_idx_q == LAST) |->
      (vid_out[W-1] &&
       vid_out[W-5] == (vid_out[W-3] ^ vid_out[W-4]) &&
       vid_out[W-6] == (vid_out[W-2] ^ vid_out[W-4]) &&
       vid_out[W-7] == (vid_out[W-2] ^ vid_out[W-3]) &&
       vid_out[W-8] == (vid_out[W-2] ^ vid_out[W-3] ^ vid_out[W-4])));

  // R6: shown active data stays inside the legal range.
  assert_limit_range_R6: assert property (@(posedge clk) disable iff (rst)
    (!code_on && tap_tag.act && !tap_tag.vbl) |=> (vid_out >= LO && vid_out <= HI));

  // R7 / R8: blanking slots carry only the two blanking levels.
  assert_blank_levels_R7: assert property (@(posedge clk) disable iff (rst)
    (!code_on && !(tap_tag.act && !tap_tag.vbl)) |=> (vid_out == CHROMA || vid_out == LUMA));

endmodule

// File: tb/test_vtrs_inserter.sv
module test_vtrs_inserter;

  localparam int W    = 10;
  localparam int NMAX = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] vid_in = '0;
  logic         act_in = 1'b0;
  logic         fld_in = 1'b0;
  logic         vbl_in = 1'b0;
  logic [W-1:0] vid_out;

  always #5 clk = ~clk;

  vtrs_inserter #(.W(W)) i_vtrs_inserter (
    .clk     (clk),
    .rst     (rst),
    .vid_in  (vid_in),
    .act_in  (act_in),
    .fld_in  (fld_in),
    .vbl_in  (vbl_in),
    .vid_out (vid_out)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int x_d [NMAX];
  bit x_a [NMAX];
  bit x_f [NMAX];
  bit x_v [NMAX];
  int n = 0;

  // class: 0 blank, 1 data, 2 start code, 3 end code, 4 active with V=1
  int exp_w [NMAX];
  int cls [NMAX];
  int kidx [NMAX];
  int codes_expected = 0;
  int ones_seen = 0;

  task automatic push(input bit a, input bit f, input bit v, input int d);
    x_a[n] = a; x_f[n] = f; x_v[n] = v; x_d[n] = d;
    n++;
  endtask

  function automatic int status_val(input int f, input int v, input int h);
    return 512 + f*256 + v*128 + h*64 + (v^h)*32 + (f^h)*16 + (f^v)*8 + (f^v^h)*4;
  endfunction

  function automatic int code_word(input int k, input int f, input int v, input int h);
    if (k == 0) return 1023;
    if (k == 3) return status_val(f, v, h);
    return 0;
  endfunction

  task automatic check(input int t);
    string req;
    int e;
    e = exp_w[t];
    case (cls[t])
      1: req = (x_d[t-4] < 4 || x_d[t-4] > 1019) ? "R6" : "R3";
      2: req = (kidx[t] == 3) ? "R5" : "R2";
      3: req = (kidx[t] == 3) ? "R5" : "R4";
      4: req = "R8";
      default: req = (t == 0) ? "R1" : "R7";
    endcase
    checks++;
    if (vid_out !== W'(e)) begin
      failures++;
      $display("FAIL %s slot %0d: actual=0x%03h expected=0x%03h", req, t, vid_out, e);
    end
    if (vid_out == 10'h3FF) ones_seen++;
    if ((vid_out == 10'h3FF || vid_out == 10'h000) && cls[t] != 2 && cls[t] != 3) begin
      checks++;
      failures++;
      $display("FAIL R10 slot %0d: actual=0x%03h expected=non-reserved", t, vid_out);
    end
  endtask

  initial begin
    int alen [6] = '{1, 2, 3, 5, 8, 40};
    int blen [3] = '{8, 9, 13};
    int dcnt = 0;
    int ph;

    // Stimulus. R9: every blanking gap is at least eight samples.
    for (int i = 0; i < 8; i++) push(0, 0, 0, 0);
    for (int fv = 0; fv < 4; fv++) begin
      for (int ai = 0; ai < 6; ai++) begin
        for (int bi = 0; bi < 3; bi++) begin
          for (int i = 0; i < alen[ai]; i++) begin
            push(1, fv[1], fv[0], (dcnt * 37 + 5) % 1024);
            dcnt++;
          end
          // Blank data at the reserved extremes must never leak out.
          for (int i = 0; i < blen[bi]; i++)
            push(0, ((fv + 1) % 4) / 2 == 1, ((fv + 1) % 2) == 1, (i % 2 == 0) ? 1023 : 0);
        end
      end
    end
    // Exhaustive limiting sweep: every 10-bit value in one active region.
    for (int i = 0; i < 1024; i++) push(1, 0, 0, i);
    for (int i = 0; i < 16; i++) push(0, 1, 1, 0);

    // Expected stream: four-word delay, then code overlays, then blanking phase.
    for (int t = 0; t < n; t++) begin
      kidx[t] = 0;
      if (t >= 4 && x_a[t-4]) begin
        if (x_v[t-4]) begin
          cls[t] = 4; exp_w[t] = 0;
        end else begin
          cls[t] = 1;
          exp_w[t] = (x_d[t-4] < 4) ? 4 : (x_d[t-4] > 1019) ? 1019 : x_d[t-4];
        end
      end else begin
        cls[t] = 0; exp_w[t] = 0;
      end
    end
    for (int t = 0; t < n; t++) begin
      bit prev;
      prev = (t == 0) ? 1'b0 : x_a[t-1];
      if (x_a[t] && !prev) begin
        codes_expected++;
        for (int k = 0; k < 4; k++) begin
          cls[t+k] = 2; kidx[t+k] = k;
          exp_w[t+k] = code_word(k, x_f[t], x_v[t], 0);
        end
      end
      if (!x_a[t] && prev) begin
        codes_expected++;
        for (int k = 0; k < 4; k++) begin
          cls[t+4+k] = 3; kidx[t+4+k] = k;
          exp_w[t+4+k] = code_word(k, x_f[t], x_v[t], 1);
        end
      end
    end
    ph = 0;
    for (int t = 0; t < n; t++) begin
      if (cls[t] == 2 || cls[t] == 3) begin
        if (kidx[t] == 3) ph = 0;
      end else begin
        if (cls[t] != 1) exp_w[t] = (ph != 0) ? 64 : 512;
        ph = 1 - ph;
      end
    end

    // R1: reset state.
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (vid_out !== 10'h040) begin
      failures++;
      $display("FAIL R1 during reset: actual=0x%03h expected=0x040", vid_out);
    end
    rst = 1'b0;

    for (int t = 0; t < n; t++) begin
      if (t > 0) begin
        @(negedge clk);
        check(t - 1);
      end
      vid_in = W'(x_d[t]); act_in = x_a[t]; fld_in = x_f[t]; vbl_in = x_v[t];
    end
    @(negedge clk);
    check(n - 1);

    // R9: every code was sent complete, none lost to an overlap.
    checks++;
    if (ones_seen != codes_expected) begin
      failures++;
      $display("FAIL R9 code count: actual=%0d expected=%0d", ones_seen, codes_expected);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule